// File: doc/BRIEF.md
# CPU Injection Frame Builder

This block takes one frame at a time from a host and turns it into the sequence of writes that a 32-bit injection queue expects. The host offers a request made of a byte length and a header of fixed word count. It then streams the payload one byte per handshake. The builder emits one write per accepted handshake on a single port. Each write is marked as either a control word or a data word.

For each frame the builder writes the following, in order:
- a start control word;
- the header words;
- the payload, packed into words;
- zero filler, when the frame is short;
- an end control word that carries the valid-byte count;
- a zero word that stands in for the checksum.

If the queue does not report ready when a request arrives, the builder refuses the frame and pulses a busy flag. After the last write it pulses a completion flag and latches the queue's watermark status as a flow-stop indication for the host.

Top module: `inj_frame_builder`

## Requirements
- R1: A request is taken only in the cycle where `req_valid`, `req_ready` and `q_ready` are all high. `req_ready` is high only while no frame is in progress, and no write is offered while it is high.
- R2: A request seen with `q_ready` low is refused. `frm_busy` is high for exactly the next cycle, no write is issued, and `req_ready` stays high.
- R3: The first write of a frame is a control word (`wr_ctrl`=1) with bit 0 (start)=1, bit 1 (end)=0, bits 3:2 (valid bytes)=0, bits 5:4 (gap)=1 and all other bits zero.
- R4: Next come the `HDR_WORDS` header words as data writes, with word k taken from `req_hdr[32k+31:32k]` as latched at the request.
- R5: Next come ceil(len/4) payload data words. Byte i of the frame sits in word i/4 at bits 8*(i%4)+7 down to 8*(i%4), and the unused bytes of a partial last word are zero.
- R6: While fewer than ceil(`MIN_BYTES`/4) payload words have been written, zero data words follow until that count is reached. This includes a zero-length frame.
- R7: The end control word has bit 1=1, bit 0=0 and gap bits 5:4=1. Its bits 3:2 hold 0 when len < `MIN_BYTES`, and len mod 4 otherwise.
- R8: The last write of a frame is one zero data word, and nothing more is written before the next request.
- R9: `frm_done` is high for one cycle, in the cycle after the final write is accepted. At that edge `flow_stop` takes the value of `q_wmark`, and it holds that value until the next `frm_done`.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_ctrl` and `wr_data` hold their values into the next cycle.
- R11: `pl_ready` is high only during the payload phase of a taken frame, and only while bytes of that frame remain unaccepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host offers a frame |
| req_ready | output | 1 | Builder idle, request can be taken |
| req_len | input | LEN_W | Frame length in bytes |
| req_hdr | input | 32*HDR_WORDS | Header words, word 0 in the low bits |
| q_ready | input | 1 | Injection queue able to take a frame |
| q_wmark | input | 1 | Queue watermark status |
| frm_busy | output | 1 | One-cycle pulse: request refused |
| pl_valid | input | 1 | Payload byte present |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte accepted when high with pl_valid |
| wr_valid | output | 1 | Queue write offered |
| wr_ready | input | 1 | Queue takes the write |
| wr_ctrl | output | 1 | 1 = control word, 0 = data word |
| wr_data | output | 32 | Write value |
| frm_done | output | 1 | One-cycle pulse after the last write |
| flow_stop | output | 1 | Watermark status latched at end of frame |

## Verification
The bench builds the block with `HDR_WORDS`=2, `LEN_W`=8 and the default `MIN_BYTES`=60. The short header keeps every frame brief. The narrow length still spans zero-length, sub-word, just-under, exactly-at and just-over-minimum frames, which makes every valid-byte encoding and every padding count reachable in a short run. Random back-pressure on the write port and gaps in the byte stream check that the filler count and the byte packing do not depend on the timing of the handshakes.

// File: rtl/inj_pkg.sv
// Shared types and helpers for the injection frame builder.
// Assumes a 32-bit queue write word. The control word layout is
// bit 0 start, bit 1 end, bits 3:2 valid bytes, bits 5:4 gap size.
package inj_pkg;

    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam logic [1:0] GAP_SIZE = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SOF,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_EOF,
        ST_CRC
    } inj_state_e;

    // Compose a queue control word from its fields.
    function automatic logic [WORD_W-1:0] ctrl_word(input logic sof,
                                                    input logic eof,
                                                    input logic [1:0] vld);
        ctrl_word = {{(WORD_W-6){1'b0}}, GAP_SIZE, vld, eof, sof};
    endfunction

endpackage

// File: rtl/inj_byte_packer.sv
// Collects payload bytes into one word, least significant lane first.
// Holds a single word. While that word waits to be taken, no byte is
// accepted. Lanes not filled before the frame's last byte stay zero,
// because the word is cleared whenever it is taken.
module inj_byte_packer #(
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_vld,
    input  logic [inj_pkg::BYTE_W-1:0] in_byte,
    input  logic                      in_last,
    output logic                      in_rdy,
    output logic [LANES*inj_pkg::BYTE_W-1:0] word,
    output logic                      word_vld,
    input  logic                      take
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(LANES - 1);

    logic [LANES*inj_pkg::BYTE_W-1:0] acc_q;
    logic [LANE_W-1:0]                lane_q;
    logic                             full_q;

    assign in_rdy   = !full_q;
    assign word     = acc_q;
    assign word_vld = full_q;

    // Place the incoming byte in its lane and mark the word complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            lane_q <= '0;
            full_q <= 1'b0;
        end else if (take) begin
            acc_q  <= '0;
            full_q <= 1'b0;
        end else if (in_vld && in_rdy) begin
            acc_q[lane_q*inj_pkg::BYTE_W +: inj_pkg::BYTE_W] <= in_byte;
            if (in_last || lane_q == LANE_LAST) begin
                full_q <= 1'b1;
                lane_q <= '0;
            end else begin
                lane_q <= lane_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/inj_seq.sv
// Frame sequencer: walks start control, header, payload, filler, end
// control and the dummy checksum word, one write per accepted handshake.
// Assumes HDR_WORDS >= 1 and that MIN_BYTES fits within LEN_W+1 bits.
module inj_seq #(
    parameter int HDR_WORDS = 9,
    parameter int LEN_W     = 12,
    parameter int MIN_BYTES = 60,
    localparam int HIDX_W   = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [LEN_W-1:0]           req_len,
    input  logic                       q_ready,
    input  logic                       q_wmark,
    output logic                       req_ready,
    output logic                       accept,
    output logic                       frm_busy,
    output logic                       frm_done,
    output logic                       flow_stop,
    output logic [HIDX_W-1:0]          hdr_idx,
    input  logic [inj_pkg::WORD_W-1:0] hdr_word,
    input  logic                       word_vld,
    input  logic [inj_pkg::WORD_W-1:0] word,
    output logic                       take,
    output logic                       byte_gate,
    output logic                       byte_last,
    input  logic                       byte_fire,
    output logic                       wr_valid,
    output logic                       wr_ctrl,
    output logic [inj_pkg::WORD_W-1:0] wr_data,
    input  logic                       wr_ready
);
    import inj_pkg::*;

    localparam int CNT_W = LEN_W + 1;
    localparam int MIN_WORDS = (MIN_BYTES + 3) / 4;
    localparam logic [CNT_W-1:0] MIN_B_C = CNT_W'(MIN_BYTES);
    localparam logic [CNT_W-1:0] MIN_W_C = CNT_W'(MIN_WORDS);
    localparam logic [HIDX_W-1:0] HLAST = HIDX_W'(HDR_WORDS - 1);

    inj_state_e        state_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  left_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic [CNT_W-1:0]  nwords;
    logic [CNT_W-1:0]  wnext;
    logic [HIDX_W-1:0] hidx_q;
    logic [1:0]        vld_bytes;
    logic              fire;

    assign nwords    = ({1'b0, len_q} + CNT_W'(3)) >> 2;
    assign wnext     = wcnt_q + 1'b1;
    assign vld_bytes = ({1'b0, len_q} < MIN_B_C) ? 2'd0 : len_q[1:0];
    assign fire      = wr_valid && wr_ready;
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready && q_ready;
    assign hdr_idx   = hidx_q;
    assign take      = (state_q == ST_PAY) && fire;
    assign byte_gate = (state_q == ST_PAY) && (left_q != '0);
    assign byte_last = (left_q == LEN_W'(1));

    // Select the write offered in the current phase.
    always_comb begin
        wr_valid = 1'b0;
        wr_ctrl  = 1'b0;
        wr_data  = '0;
        unique case (state_q)
            ST_SOF: begin
                wr_valid = 1'b1;
                wr_ctrl  = 1'b1;
                wr_data  = ctrl_word(1'b1, 1'b0, 2'd0);
            end
            ST_HDR: begin
                wr_valid = 1'b1;
                wr_data  = hdr_word;
            end
            ST_PAY: begin
                wr_valid = word_vld;
                wr_data  = word;
            end
            ST_PAD: wr_valid = 1'b1;
            ST_EOF: begin
                wr_valid = 1'b1;
                wr_ctrl  = 1'b1;
                wr_data  = ctrl_word(1'b0, 1'b1, vld_bytes);
            end
            ST_CRC: wr_valid = 1'b1;
            default: ;
        endcase
    end

    // Advance through the frame phases and keep the word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            len_q     <= '0;
            left_q    <= '0;
            wcnt_q    <= '0;
            hidx_q    <= '0;
            frm_busy  <= 1'b0;
            frm_done  <= 1'b0;
            flow_stop <= 1'b0;
        end else begin
            frm_busy <= req_valid && req_ready && !q_ready;
            frm_done <= 1'b0;
            if (byte_fire) begin
                left_q <= left_q - 1'b1;
            end
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    len_q   <= req_len;
                    left_q  <= req_len;
                    state_q <= ST_SOF;
                end
                ST_SOF: if (fire) begin
                    hidx_q  <= '0;
                    state_q <= ST_HDR;
                end
                ST_HDR: if (fire) begin
                    if (hidx_q == HLAST) begin
                        wcnt_q <= '0;
                        if (len_q != '0) begin
                            state_q <= ST_PAY;
                        end else if (MIN_WORDS > 0) begin
                            state_q <= ST_PAD;
                        end else begin
                            state_q <= ST_EOF;
                        end
                    end else begin
                        hidx_q <= hidx_q + 1'b1;
                    end
                end
                ST_PAY: if (fire) begin
                    wcnt_q <= wnext;
                    if (wnext == nwords) begin
                        state_q <= (wnext < MIN_W_C) ? ST_PAD : ST_EOF;
                    end
                end
                ST_PAD: if (fire) begin
                    wcnt_q <= wnext;
                    if (wnext >= MIN_W_C) begin
                        state_q <= ST_EOF;
                    end
                end
                ST_EOF: if (fire) begin
                    state_q <= ST_CRC;
                end
                ST_CRC: if (fire) begin
                    state_q   <= ST_IDLE;
                    frm_done  <= 1'b1;
                    flow_stop <= q_wmark;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/inj_frame_builder.sv
// Top of the injection frame builder. Latches the header at request
// time, packs payload bytes into words and lets the sequencer order the
// queue writes. Assumes the host holds pl_data stable while pl_valid is
// high and not accepted.
module inj_frame_builder #(
    parameter int HDR_WORDS = 9,
    parameter int LEN_W     = 12,
    parameter int MIN_BYTES = 60
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [32*HDR_WORDS-1:0] req_hdr,
    input  logic                    q_ready,
    input  logic                    q_wmark,
    output logic                    frm_busy,
    input  logic                    pl_valid,
    input  logic [7:0]              pl_data,
    output logic                    pl_ready,
    output logic                    wr_valid,
    input  logic                    wr_ready,
    output logic                    wr_ctrl,
    output logic [31:0]             wr_data,
    output logic                    frm_done,
    output logic                    flow_stop
);
    localparam int HIDX_W = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;
    localparam int LANES  = inj_pkg::WORD_W / inj_pkg::BYTE_W;

    logic [inj_pkg::WORD_W-1:0] hdr_q [HDR_WORDS];
    logic [HIDX_W-1:0]          hdr_idx;
    logic [inj_pkg::WORD_W-1:0] hdr_word;
    logic                       accept;
    logic                       take;
    logic                       byte_gate;
    logic                       byte_last;
    logic                       byte_fire;
    logic                       pk_rdy;
    logic                       word_vld;
    logic [inj_pkg::WORD_W-1:0] word;

    // One holding register per header word, loaded when a frame is taken.
    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_hdr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hdr_q[g] <= '0;
            end else if (accept) begin
                hdr_q[g] <= req_hdr[g*32 +: 32];
            end
        end
    end

    assign hdr_word  = hdr_q[hdr_idx];
    assign pl_ready  = byte_gate && pk_rdy;
    assign byte_fire = pl_valid && pl_ready;

    inj_byte_packer #(
        .LANES(LANES)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (pl_valid && byte_gate),
        .in_byte  (pl_data),
        .in_last  (byte_last),
        .in_rdy   (pk_rdy),
        .word     (word),
        .word_vld (word_vld),
        .take     (take)
    );

    inj_seq #(
        .HDR_WORDS (HDR_WORDS),
        .LEN_W     (LEN_W),
        .MIN_BYTES (MIN_BYTES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_len   (req_len),
        .q_ready   (q_ready),
        .q_wmark   (q_wmark),
        .req_ready (req_ready),
        .accept    (accept),
        .frm_busy  (frm_busy),
        .frm_done  (frm_done),
        .flow_stop (flow_stop),
        .hdr_idx   (hdr_idx),
        .hdr_word  (hdr_word),
        .word_vld  (word_vld),
        .word      (word),
        .take      (take),
        .byte_gate (byte_gate),
        .byte_last (byte_last),
        .byte_fire (byte_fire),
        .wr_valid  (wr_valid),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready)
    );

endmodule

// File: rtl/inj_frame_chk.sv
// Port-level protocol checks for the injection frame builder, attached
// by bind. Assumes the control word layout in inj_pkg.
module inj_frame_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        q_ready,
    input logic        pl_ready,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic        wr_ctrl,
    input logic [31:0] wr_data,
    input logic        frm_busy,
    input logic        frm_done,
    input logic        flow_stop
);
    // R1: an idle builder offers no write
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !wr_valid);

    // R2: a refused request pulses busy and leaves the builder idle
    p_refuse_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !q_ready) |=> (frm_busy && req_ready));

    // R3: a taken request is followed by a start control word
    p_start_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && q_ready) |=>
            (wr_valid && wr_ctrl && wr_data[0] && !wr_data[1]));

    // R7: every control word carries gap size 1 and no stray bits
    p_ctrl_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ctrl) |-> (wr_data[5:4] == 2'd1 && wr_data[31:6] == '0));

    // R9: completion is a single-cycle pulse seen from an idle builder
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done);
    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |-> req_ready);
    p_flow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> (frm_done || $stable(flow_stop)));

    // R10: a stalled write holds still
    p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=>
            (wr_valid && $stable(wr_data) && $stable(wr_ctrl)));

    // R11: no payload bytes taken while idle
    p_pl_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> !req_ready);

endmodule

bind inj_frame_builder inj_frame_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .q_ready   (q_ready),
    .pl_ready  (pl_ready),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_ctrl   (wr_ctrl),
    .wr_data   (wr_data),
    .frm_busy  (frm_busy),
    .frm_done  (frm_done),
    .flow_stop (flow_stop)
);

// File: tb/sim_inj_frame_builder.sv
// Bench for the injection frame builder. A behavioural model builds the
// expected write list per frame and is compared on every clock.
module sim_inj_frame_builder;
    localparam int HW   = 2;
    localparam int LW   = 8;
    localparam int MINB = 60;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [LW-1:0]  req_len = '0;
    logic [32*HW-1:0] req_hdr = '0;
    logic           q_ready = 1'b0;
    logic           q_wmark = 1'b0;
    logic           frm_busy;
    logic           pl_valid = 1'b0;
    logic [7:0]     pl_data = '0;
    logic           pl_ready;
    logic           wr_valid;
    logic           wr_ready = 1'b0;
    logic           wr_ctrl;
    logic [31:0]    wr_data;
    logic           frm_done;
    logic           flow_stop;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit last_wm = 1'b0;

    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [7:0]  pay[$];

    always #4 clk = ~clk;

    inj_frame_builder #(.HDR_WORDS(HW), .LEN_W(LW), .MIN_BYTES(MINB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_len(req_len), .req_hdr(req_hdr), .q_ready(q_ready),
        .q_wmark(q_wmark), .frm_busy(frm_busy), .pl_valid(pl_valid),
        .pl_data(pl_data), .pl_ready(pl_ready), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_ctrl(wr_ctrl), .wr_data(wr_data),
        .frm_done(frm_done), .flow_stop(flow_stop)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Build the expected write list for one frame.
    task automatic model(input int len, input logic [32*HW-1:0] hdr, input int seed);
        int nw;
        logic [31:0] w;
        exp_q.delete(); tag_q.delete(); pay.delete();
        for (int i = 0; i < len; i++) pay.push_back(8'((seed + i * 7 + 1) & 8'hff));
        exp_q.push_back({1'b1, 32'h0000_0011}); tag_q.push_back("R3");
        for (int k = 0; k < HW; k++) begin
            exp_q.push_back({1'b0, hdr[k*32 +: 32]}); tag_q.push_back("R4");
        end
        nw = (len + 3) / 4;
        for (int k = 0; k < nw; k++) begin
            w = '0;
            for (int b = 0; b < 4; b++)
                if (k * 4 + b < len) w[b*8 +: 8] = pay[k*4 + b];
            exp_q.push_back({1'b0, w}); tag_q.push_back("R5");
        end
        for (int k = nw; k < (MINB + 3) / 4; k++) begin
            exp_q.push_back({1'b0, 32'h0}); tag_q.push_back("R6");
        end
        w = 32'h0000_0012;
        if (len >= MINB) w[3:2] = 2'(len % 4);
        exp_q.push_back({1'b1, w}); tag_q.push_back("R7");
        exp_q.push_back({1'b0, 32'h0}); tag_q.push_back("R8");
    endtask

    task automatic run_frame(input int len, input bit wm, input bit stall, input int seed);
        logic [32*HW-1:0] hdr;
        int bi = 0;
        int n = 0;
        bit seen = 0;
        bit held = 0;
        logic [32:0] held_v;
        for (int k = 0; k < HW; k++) hdr[k*32 +: 32] = 32'hA500_0000 + 32'(seed * 16 + k);
        model(len, hdr, seed);
        @(negedge clk);
        req_valid = 1'b1; req_len = LW'(len); req_hdr = hdr;
        q_ready = 1'b1; q_wmark = wm;
        #1 chk(req_ready, "R1 idle before request", {63'd0, req_ready}, 64'd1);
        while (!seen && n < 3000) begin
            @(negedge clk);
            n++;
            req_valid = 1'b0;
            wr_ready = stall ? (($urandom % 3) != 0) : 1'b1;
            pl_valid = (bi < len) && (stall ? (($urandom % 2) == 0) : 1'b1);
            pl_data = (bi < len) ? pay[bi] : 8'h00;
            #1;
            chk(!(pl_ready && bi >= len), "R11 byte request past frame end",
                {63'd0, pl_ready}, 64'd0);
            if (held)
                chk(wr_valid && {wr_ctrl, wr_data} == held_v, "R10 stalled write held",
                    {31'd0, wr_valid, wr_ctrl, wr_data}, {31'd0, 1'b1, held_v});
            held = wr_valid && !wr_ready;
            held_v = {wr_ctrl, wr_data};
            if (pl_valid && pl_ready) bi++;
            if (wr_valid && wr_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8 extra write", {31'd0, wr_ctrl, wr_data}, 64'd0);
                end else begin
                    chk({wr_ctrl, wr_data} == exp_q[0], tag_q[0],
                        {31'd0, wr_ctrl, wr_data}, {31'd0, exp_q[0]});
                    void'(exp_q.pop_front()); void'(tag_q.pop_front());
                end
            end
            if (frm_done) begin
                seen = 1;
                chk(exp_q.size() == 0, "R9 done after all writes", 64'(exp_q.size()), 64'd0);
                chk(flow_stop == wm, "R9 flow_stop latched", {63'd0, flow_stop}, {63'd0, wm});
                chk(req_ready, "R1 idle at done", {63'd0, req_ready}, 64'd1);
            end else begin
                chk(flow_stop == last_wm, "R9 flow_stop held", {63'd0, flow_stop},
                    {63'd0, last_wm});
            end
        end
        chk(seen, "R9 done seen", {63'd0, seen}, 64'd1);
        last_wm = wm;
        pl_valid = 1'b0;
        @(negedge clk);
        #1 chk(!frm_done, "R9 done single cycle", {63'd0, frm_done}, 64'd0);
        chk(!wr_valid, "R8 no write after frame", {63'd0, wr_valid}, 64'd0);
    endtask

    task automatic refuse();
        @(negedge clk);
        q_ready = 1'b0; req_valid = 1'b1; req_len = LW'(10);
        pl_valid = 1'b1; pl_data = 8'h5a; wr_ready = 1'b1;
        #1 chk(req_ready, "R2 idle when refused", {63'd0, req_ready}, 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(frm_busy, "R2 busy pulse", {63'd0, frm_busy}, 64'd1);
        chk(!wr_valid, "R2 no write after refusal", {63'd0, wr_valid}, 64'd0);
        chk(req_ready, "R2 stays idle", {63'd0, req_ready}, 64'd1);
        chk(!pl_ready, "R11 no byte taken when idle", {63'd0, pl_ready}, 64'd0);
        @(negedge clk);
        #1;
        chk(!frm_busy, "R2 busy one cycle", {63'd0, frm_busy}, 64'd0);
        chk(!wr_valid, "R2 still no write", {63'd0, wr_valid}, 64'd0);
        pl_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready, "R1 reset idle", {63'd0, req_ready}, 64'd1);
        chk(!wr_valid, "R1 reset no write", {63'd0, wr_valid}, 64'd0);
        chk(!frm_done && !frm_busy, "R9 reset pulses low",
            {62'd0, frm_done, frm_busy}, 64'd0);
        chk(!flow_stop, "R9 reset flow_stop", {63'd0, flow_stop}, 64'd0);
        run_frame(0, 1'b1, 1'b0, 1);
        run_frame(1, 1'b0, 1'b1, 2);
        run_frame(4, 1'b1, 1'b0, 3);
        run_frame(5, 1'b1, 1'b1, 4);
        refuse();
        run_frame(59, 1'b0, 1'b1, 5);
        run_frame(60, 1'b0, 1'b0, 6);
        run_frame(61, 1'b1, 1'b1, 7);
        run_frame(63, 1'b0, 1'b1, 8);
        run_frame(66, 1'b1, 1'b0, 9);
        run_frame(100, 1'b0, 1'b1, 10);
        run_frame(255, 1'b1, 1'b1, 11);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule